// File: doc/BRIEF.md
# Pin Function Multiplexing Controller

This block decides, for each of 52 general-purpose pins, which on-chip function drives the pad and which function receives its input. Four software-programmed select registers sit behind a small memory-mapped port. For any pin, the owner is one of five sources: the GPIO block, the LED controller, a per-pin alternate function, a wide secondary (wireless) function, or a dedicated peripheral group.

Pins 0 to 31 form the first bank and pins 32 to 51 form the second bank. The two banks are not programmed the same way. First-bank pins use an active-high mode select. Second-bank pins use an active-low control select. Group override bits claim whole sets of pins at once, and the sets can overlap, so pins 24 to 27 each answer to two override bits.

The owning source drives the pad output value and the output enable. A 3-bit code per pin reports which source won. Pad input data always reaches the GPIO input. Each other function receives the pad input only on the pins it currently owns.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset, the mode, LED and group registers read 0. The control register reads 0x000FFFFF. Every pin reports source code 0 (GPIO) and carries the GPIO output and enable.
- R2: A write to offset 0x10 (LED), 0x18 (mode), 0x1C (control) or 0x38 (group) stores the full 32-bit word at the next rising clock edge. While `bus_rd` is high, `bus_rdata` returns the stored word. Any other offset reads 0 and a write to it changes nothing. `bus_rdata` is 0 while `bus_rd` is low.
- R3: For a first-bank pin n with no group claim, mode bit n set to 1 selects the alternate function (code 2). Mode bit n at 0 leaves the choice to the LED bit or GPIO.
- R4: For pins 0 to 23, when neither a group claim nor the mode bit applies, LED bit n set to 1 selects the LED controller (code 1). LED bits 24 to 31 never affect any pin.
- R5: For a second-bank pin 32+k with no group claim, control bit k at 0 selects the secondary function (code 3) and control bit k at 1 selects GPIO. Second-bank pins never report codes 1 or 2, and first-bank pins never report code 3.
- R6: Group bits claim pins for the dedicated peripheral (code 4), as follows:
  - bit 2 claims pins 2 to 7 and 24 to 31;
  - bit 5 claims pins 8 and 9;
  - bit 6 claims pins 10 and 11;
  - bit 7 claims pins 12 and 13;
  - bit 8 claims pins 24 and 25;
  - bit 9 claims pins 26 and 27;
  - bit 4 claims pin 35 only.
  
  All other group bits have no effect.
- R7: Each of pins 24 to 27 stays claimed by its group while either of its two covering bits is set. It is released only when both covering bits are clear.
- R8: Selection priority, highest first, is: group claim, then mode bit (first bank) or control bit (second bank), then LED bit, then GPIO.
- R9: `pad_out` and `pad_oe` follow the winning source's output and enable. The LED controller's enable is always 1. The source codes are 0 GPIO, 1 LED, 2 alternate, 3 secondary and 4 group.
- R10: `gpio_in` always equals `pad_in`. The alternate, secondary and group input buses carry `pad_in` on the pins their function owns and 0 on all other pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| gpio_out | input | 52 | GPIO output values |
| gpio_oe | input | 52 | GPIO output enables |
| led_out | input | 24 | LED controller outputs, pins 0 to 23 |
| alt_out | input | 32 | Alternate function outputs, first bank |
| alt_oe | input | 32 | Alternate function enables, first bank |
| sec_out | input | 20 | Secondary function outputs, second bank |
| sec_oe | input | 20 | Secondary function enables, second bank |
| grp_out | input | 52 | Dedicated group outputs |
| grp_oe | input | 52 | Dedicated group enables |
| pad_in | input | 52 | Pad input data |
| pad_out | output | 52 | Pad output value |
| pad_oe | output | 52 | Pad output enable |
| pad_src | output | 156 | 3-bit source code per pin, pin n at bits 3n+2:3n |
| gpio_in | output | 52 | Pad input to GPIO |
| alt_in | output | 32 | Pad input to alternate functions |
| sec_in | output | 20 | Pad input to secondary function |
| grp_in | output | 52 | Pad input to group peripherals |

## Verification
The assertions check the following on every cycle:
- a write to a defined offset lands on the next edge, and a write to an undefined offset leaves every register stable;
- no pin ever shows a code outside 0 to 4, and the codes respect each bank's limits (LED only on pins 0 to 23, alternate only in the first bank, secondary only in the second bank);
- pin 35 and the overlapped pins 24 to 27 stay claimed while their group bits are set;
- function inputs are zero wherever that function does not own the pin.

The bench's scenarios are needed for the rest:
- the exact group-bit-to-pin map;
- the inverted polarity of the control register;
- the full priority order between group, mode and LED;
- release of an overlapped pin only after both of its bits clear;
- the one-edge latency from a write to a change in pad ownership.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int unsigned DW    = 32;
    localparam int unsigned AW    = 8;
    localparam int unsigned SRC_W = 3;

    localparam logic [AW-1:0] OFF_LED  = 8'h10;
    localparam logic [AW-1:0] OFF_MODE = 8'h18;
    localparam logic [AW-1:0] OFF_CTRL = 8'h1C;
    localparam logic [AW-1:0] OFF_GRP  = 8'h38;

    // group override bit positions
    localparam int unsigned GB_WIDE = 2;
    localparam int unsigned GB_P35  = 4;
    localparam int unsigned GB_P8   = 5;
    localparam int unsigned GB_P10  = 6;
    localparam int unsigned GB_P12  = 7;
    localparam int unsigned GB_P24  = 8;
    localparam int unsigned GB_P26  = 9;

    typedef enum logic [SRC_W-1:0] {
        SRC_GPIO = 3'd0,
        SRC_LED  = 3'd1,
        SRC_ALT  = 3'd2,
        SRC_SEC  = 3'd3,
        SRC_GRP  = 3'd4
    } src_e;

    typedef struct packed {
        logic [DW-1:0] led;
        logic [DW-1:0] mode;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] grp;
    } cfg_t;

    // Is this pin claimed by any of its covering group bits?
    function automatic logic group_claim(input int unsigned pin, input logic [DW-1:0] g);
        logic c;
        c = 1'b0;
        if ((pin >= 2 && pin <= 7) || (pin >= 24 && pin <= 31)) c = c | g[GB_WIDE];
        if (pin == 8  || pin == 9)  c = c | g[GB_P8];
        if (pin == 10 || pin == 11) c = c | g[GB_P10];
        if (pin == 12 || pin == 13) c = c | g[GB_P12];
        if (pin == 24 || pin == 25) c = c | g[GB_P24];
        if (pin == 26 || pin == 27) c = c | g[GB_P26];
        if (pin == 35)              c = c | g[GB_P35];
        return c;
    endfunction

endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int unsigned SEC_PINS = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output cfg_t          cfg_o
);

    localparam logic [DW-1:0] CTRL_RST = DW'((64'd1 << SEC_PINS) - 64'd1);
    localparam cfg_t CFG_RST = '{led: '0, mode: '0, ctrl: CTRL_RST, grp: '0};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr) begin
            case (bus_addr)
                OFF_LED:  cfg_d.led  = bus_wdata;
                OFF_MODE: cfg_d.mode = bus_wdata;
                OFF_CTRL: cfg_d.ctrl = bus_wdata;
                OFF_GRP:  cfg_d.grp  = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFF_LED:  bus_rdata = cfg_q.led;
                OFF_MODE: bus_rdata = cfg_q.mode;
                OFF_CTRL: bus_rdata = cfg_q.ctrl;
                OFF_GRP:  bus_rdata = cfg_q.grp;
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    logic addr_known;
    assign addr_known = (bus_addr == OFF_LED) || (bus_addr == OFF_MODE) ||
                        (bus_addr == OFF_CTRL) || (bus_addr == OFF_GRP);

    p_mode_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_MODE) |=> (cfg_q.mode == $past(bus_wdata)))
        else $error("mode write not stored");

    p_grp_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_GRP) |=> (cfg_q.grp == $past(bus_wdata)))
        else $error("group write not stored");

    p_undef_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !addr_known) |=> $stable(cfg_q))
        else $error("write to undefined offset changed state");

endmodule

// File: rtl/pinmux_owner.sv
module pinmux_owner
    import pinmux_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 52,
    parameter int unsigned BANK_PINS = 32,
    parameter int unsigned LED_PINS  = 24
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  cfg_t                           cfg,
    output logic [NUM_PINS-1:0][SRC_W-1:0] src_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic claim;
        src_e sel;
        assign claim    = group_claim(p, cfg.grp);
        assign src_o[p] = sel;

        if (p < BANK_PINS) begin : g_bank1
            logic led_sel;
            if (p < LED_PINS) begin : g_led
                assign led_sel = cfg.led[p];
            end else begin : g_noled
                assign led_sel = 1'b0;
            end

            always_comb begin
                if (claim)            sel = SRC_GRP;
                else if (cfg.mode[p]) sel = SRC_ALT;
                else if (led_sel)     sel = SRC_LED;
                else                  sel = SRC_GPIO;
            end

            p_no_sec_first_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
                src_o[p] != SRC_SEC)
                else $error("secondary code on first-bank pin %0d", p);

            if (p >= LED_PINS) begin : g_chk_led
                p_led_limited_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    src_o[p] != SRC_LED)
                    else $error("LED code on pin %0d", p);
            end
        end else begin : g_bank2
            always_comb begin
                if (claim)                        sel = SRC_GRP;
                else if (!cfg.ctrl[p-BANK_PINS])  sel = SRC_SEC;
                else                              sel = SRC_GPIO;
            end

            p_bank2_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (src_o[p] != SRC_ALT) && (src_o[p] != SRC_LED))
                else $error("illegal code on second-bank pin %0d", p);
        end

        p_src_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
            src_o[p] <= SRC_GRP)
            else $error("undefined source code on pin %0d", p);
    end

endmodule

// File: rtl/pinmux_pad.sv
module pinmux_pad
    import pinmux_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 52,
    parameter int unsigned BANK_PINS = 32,
    parameter int unsigned LED_PINS  = 24,
    localparam int unsigned SEC_PINS = NUM_PINS - BANK_PINS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0][SRC_W-1:0] src,
    input  logic [NUM_PINS-1:0]            gpio_out,
    input  logic [NUM_PINS-1:0]            gpio_oe,
    input  logic [LED_PINS-1:0]            led_out,
    input  logic [BANK_PINS-1:0]           alt_out,
    input  logic [BANK_PINS-1:0]           alt_oe,
    input  logic [SEC_PINS-1:0]            sec_out,
    input  logic [SEC_PINS-1:0]            sec_oe,
    input  logic [NUM_PINS-1:0]            grp_out,
    input  logic [NUM_PINS-1:0]            grp_oe,
    input  logic [NUM_PINS-1:0]            pad_in,
    output logic [NUM_PINS-1:0]            pad_out,
    output logic [NUM_PINS-1:0]            pad_oe,
    output logic [BANK_PINS-1:0]           alt_in,
    output logic [SEC_PINS-1:0]            sec_in,
    output logic [NUM_PINS-1:0]            grp_in
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic led_o, alt_o, alt_e, sec_o, sec_e;

        if (p < BANK_PINS) begin : g_bank1
            assign alt_o     = alt_out[p];
            assign alt_e     = alt_oe[p];
            assign sec_o     = 1'b0;
            assign sec_e     = 1'b0;
            assign alt_in[p] = pad_in[p] & (src[p] == SRC_ALT);

            p_alt_in_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (src[p] != SRC_ALT) |-> (alt_in[p] == 1'b0))
                else $error("alternate input leaks on pin %0d", p);
        end else begin : g_bank2
            assign alt_o = 1'b0;
            assign alt_e = 1'b0;
            assign sec_o = sec_out[p-BANK_PINS];
            assign sec_e = sec_oe[p-BANK_PINS];
            assign sec_in[p-BANK_PINS] = pad_in[p] & (src[p] == SRC_SEC);
        end

        if (p < LED_PINS) begin : g_led
            assign led_o = led_out[p];
        end else begin : g_noled
            assign led_o = 1'b0;
        end

        always_comb begin
            case (src[p])
                SRC_LED: begin pad_out[p] = led_o;      pad_oe[p] = 1'b1;       end
                SRC_ALT: begin pad_out[p] = alt_o;      pad_oe[p] = alt_e;      end
                SRC_SEC: begin pad_out[p] = sec_o;      pad_oe[p] = sec_e;      end
                SRC_GRP: begin pad_out[p] = grp_out[p]; pad_oe[p] = grp_oe[p];  end
                default: begin pad_out[p] = gpio_out[p]; pad_oe[p] = gpio_oe[p]; end
            endcase
        end

        assign grp_in[p] = pad_in[p] & (src[p] == SRC_GRP);

        p_led_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (src[p] == SRC_LED) |-> pad_oe[p])
            else $error("LED-owned pin %0d not enabled", p);
    end

endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
    import pinmux_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 52,
    parameter int unsigned BANK_PINS = 32,
    parameter int unsigned LED_PINS  = 24,
    localparam int unsigned SEC_PINS = NUM_PINS - BANK_PINS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_PINS-1:0]       gpio_out,
    input  logic [NUM_PINS-1:0]       gpio_oe,
    input  logic [LED_PINS-1:0]       led_out,
    input  logic [BANK_PINS-1:0]      alt_out,
    input  logic [BANK_PINS-1:0]      alt_oe,
    input  logic [SEC_PINS-1:0]       sec_out,
    input  logic [SEC_PINS-1:0]       sec_oe,
    input  logic [NUM_PINS-1:0]       grp_out,
    input  logic [NUM_PINS-1:0]       grp_oe,
    input  logic [NUM_PINS-1:0]       pad_in,
    output logic [NUM_PINS-1:0]       pad_out,
    output logic [NUM_PINS-1:0]       pad_oe,
    output logic [NUM_PINS*SRC_W-1:0] pad_src,
    output logic [NUM_PINS-1:0]       gpio_in,
    output logic [BANK_PINS-1:0]      alt_in,
    output logic [SEC_PINS-1:0]       sec_in,
    output logic [NUM_PINS-1:0]       grp_in
);

    cfg_t                           cfg;
    logic [NUM_PINS-1:0][SRC_W-1:0] src;

    pinmux_regs #(.SEC_PINS(SEC_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg)
    );

    pinmux_owner #(.NUM_PINS(NUM_PINS), .BANK_PINS(BANK_PINS), .LED_PINS(LED_PINS)) u_owner (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (cfg),
        .src_o (src)
    );

    pinmux_pad #(.NUM_PINS(NUM_PINS), .BANK_PINS(BANK_PINS), .LED_PINS(LED_PINS)) u_pad (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .gpio_out (gpio_out),
        .gpio_oe  (gpio_oe),
        .led_out  (led_out),
        .alt_out  (alt_out),
        .alt_oe   (alt_oe),
        .sec_out  (sec_out),
        .sec_oe   (sec_oe),
        .grp_out  (grp_out),
        .grp_oe   (grp_oe),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .alt_in   (alt_in),
        .sec_in   (sec_in),
        .grp_in   (grp_in)
    );

    assign pad_src = src;
    assign gpio_in = pad_in;

    // group claims seen from the register state through to the reported codes
    p_pin35_claimed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.grp[GB_P35] |-> (pad_src[35*SRC_W +: SRC_W] == SRC_GRP))
        else $error("pin 35 not claimed");

    p_pin24_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.grp[GB_WIDE] || cfg.grp[GB_P24]) |-> (pad_src[24*SRC_W +: SRC_W] == SRC_GRP))
        else $error("pin 24 released while covered");

    p_pin27_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.grp[GB_WIDE] || cfg.grp[GB_P26]) |-> (pad_src[27*SRC_W +: SRC_W] == SRC_GRP))
        else $error("pin 27 released while covered");

endmodule

// File: tb/sim_pinmux_ctrl.sv
`timescale 1ns/1ps
module sim_pinmux_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [51:0] gpio_out, gpio_oe, grp_out, grp_oe, pad_in;
    logic [23:0] led_out;
    logic [31:0] alt_out, alt_oe;
    logic [19:0] sec_out, sec_oe;
    logic [51:0] pad_out, pad_oe, gpio_in, grp_in;
    logic [155:0] pad_src;
    logic [31:0] alt_in;
    logic [19:0] sec_in;

    pinmux_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .led_out(led_out),
        .alt_out(alt_out), .alt_oe(alt_oe), .sec_out(sec_out), .sec_oe(sec_oe),
        .grp_out(grp_out), .grp_oe(grp_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_src(pad_src),
        .gpio_in(gpio_in), .alt_in(alt_in), .sec_in(sec_in), .grp_in(grp_in)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] sh_led = 0, sh_mode = 0, sh_ctrl = 32'h000F_FFFF, sh_grp = 0;

    task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit m_claim(input int p);
        case (p)
            2, 3, 4, 5, 6, 7, 28, 29, 30, 31: return sh_grp[2];
            8, 9:   return sh_grp[5];
            10, 11: return sh_grp[6];
            12, 13: return sh_grp[7];
            24, 25: return sh_grp[2] | sh_grp[8];
            26, 27: return sh_grp[2] | sh_grp[9];
            35:     return sh_grp[4];
            default: return 1'b0;
        endcase
    endfunction

    function automatic int m_src(input int p);
        if (m_claim(p)) return 4;
        if (p < 32) begin
            if (sh_mode[p]) return 2;
            if (p < 24 && sh_led[p]) return 1;
            return 0;
        end
        return sh_ctrl[p-32] ? 0 : 3;
    endfunction

    function automatic logic [2:0] got_src(input int p);
        return pad_src[p*3 +: 3];
    endfunction

    // full comparison of all pins against the requirement model
    task automatic full_cmp(input string tag);
        logic [155:0] es;
        logic [51:0]  eo, ee, eg;
        logic [31:0]  ea;
        logic [19:0]  ec;
        es = '0; eo = '0; ee = '0; eg = '0; ea = '0; ec = '0;
        for (int p = 0; p < 52; p++) begin
            int s;
            s = m_src(p);
            es[p*3 +: 3] = 3'(s);
            case (s)
                1: begin eo[p] = led_out[p];     ee[p] = 1'b1;        end
                2: begin eo[p] = alt_out[p];     ee[p] = alt_oe[p];   end
                3: begin eo[p] = sec_out[p-32];  ee[p] = sec_oe[p-32]; end
                4: begin eo[p] = grp_out[p];     ee[p] = grp_oe[p];   end
                default: begin eo[p] = gpio_out[p]; ee[p] = gpio_oe[p]; end
            endcase
            if (s == 2) ea[p] = pad_in[p];
            if (s == 3) ec[p-32] = pad_in[p];
            if (s == 4) eg[p] = pad_in[p];
        end
        chk({tag, " src"}, 160'(pad_src), 160'(es));
        chk("R9 pad_out", 160'(pad_out), 160'(eo));
        chk("R9 pad_oe", 160'(pad_oe), 160'(ee));
        chk("R10 gpio_in", 160'(gpio_in), 160'(pad_in));
        chk("R10 alt_in", 160'(alt_in), 160'(ea));
        chk("R10 sec_in", 160'(sec_in), 160'(ec));
        chk("R10 grp_in", 160'(grp_in), 160'(eg));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 0;
        case (a)
            8'h10: sh_led = d;
            8'h18: sh_mode = d;
            8'h1C: sh_ctrl = d;
            8'h38: sh_grp = d;
            default: ;
        endcase
        #2;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h10, v); chk("R1 led reset", 160'(v), 160'(0));
        rd(8'h18, v); chk("R1 mode reset", 160'(v), 160'(0));
        rd(8'h1C, v); chk("R1 ctrl reset", 160'(v), 160'(32'h000F_FFFF));
        rd(8'h38, v); chk("R1 grp reset", 160'(v), 160'(0));
        full_cmp("R1 reset");
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(8'h18, 32'h1234_5678);
        rd(8'h18, v); chk("R2 mode readback", 160'(v), 160'(32'h1234_5678));
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R2 undefined reads 0", 160'(v), 160'(0));
        rd(8'h18, v); chk("R2 undefined write ignored", 160'(v), 160'(32'h1234_5678));
        rd(8'h38, v); chk("R2 grp untouched", 160'(v), 160'(0));
        #1; bus_addr = 8'h18;
        #1; chk("R2 rdata idle", 160'(bus_rdata), 160'(0));
        full_cmp("R2 after writes");
        wr(8'h18, 32'h0);
    endtask

    task automatic t_mode();
        // latency: nothing changes before the edge
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'h18; bus_wdata = 32'hFFFF_FFFF;
        #1; chk("R2 no change before edge", 160'(got_src(0)), 160'(0));
        @(posedge clk); #1; bus_wr = 0; sh_mode = 32'hFFFF_FFFF; #2;
        chk("R3 alt after edge", 160'(got_src(0)), 160'(2));
        full_cmp("R3 all alt");
        wr(8'h18, 32'hA5A5_0F0F);
        full_cmp("R3 pattern");
        wr(8'h18, 32'h0);
    endtask

    task automatic t_led();
        wr(8'h10, 32'hFFFF_FFFF);
        chk("R4 pin5 led", 160'(got_src(5)), 160'(1));
        chk("R4 pin25 no led", 160'(got_src(25)), 160'(0));
        chk("R4 pin31 no led", 160'(got_src(31)), 160'(0));
        full_cmp("R4 led all");
        wr(8'h10, 32'h0055_AA33);
        full_cmp("R4 led pattern");
        wr(8'h10, 32'h0);
    endtask

    task automatic t_ctrl();
        wr(8'h1C, 32'h0);
        chk("R5 pin32 sec", 160'(got_src(32)), 160'(3));
        chk("R5 pin51 sec", 160'(got_src(51)), 160'(3));
        full_cmp("R5 all sec");
        wr(8'h1C, 32'h000A_AAAA);
        chk("R5 pin33 gpio", 160'(got_src(33)), 160'(0));
        chk("R5 pin32 sec", 160'(got_src(32)), 160'(3));
        full_cmp("R5 pattern");
    endtask

    task automatic t_group();
        int bits[8] = '{2, 3, 4, 5, 6, 7, 8, 9};
        foreach (bits[i]) begin
            wr(8'h38, 32'(1) << bits[i]);
            full_cmp("R6 group bit");
        end
        wr(8'h38, 32'h0000_0010);
        chk("R6 pin35 group", 160'(got_src(35)), 160'(4));
        chk("R6 pin34 not group", 160'(got_src(34)), 160'(3));
        wr(8'h38, 32'hFFFF_FC0B);
        full_cmp("R6 undefined bits");
        wr(8'h38, 32'h0);
    endtask

    task automatic t_overlap();
        wr(8'h38, 32'h0000_0100);
        chk("R7 pin24 by bit8", 160'(got_src(24)), 160'(4));
        chk("R7 pin26 free", 160'(got_src(26)), 160'(0));
        wr(8'h38, 32'h0000_0104);
        full_cmp("R7 both");
        wr(8'h38, 32'h0000_0004);
        chk("R7 pin24 still by bit2", 160'(got_src(24)), 160'(4));
        wr(8'h38, 32'h0000_0200);
        chk("R7 pin27 by bit9", 160'(got_src(27)), 160'(4));
        chk("R7 pin24 released", 160'(got_src(24)), 160'(0));
        wr(8'h38, 32'h0);
        chk("R7 pin27 released", 160'(got_src(27)), 160'(0));
    endtask

    task automatic t_prio();
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h38, 32'h0000_0020);
        chk("R8 group over mode", 160'(got_src(8)), 160'(4));
        chk("R8 mode over led", 160'(got_src(0)), 160'(2));
        wr(8'h18, 32'h0);
        chk("R8 led over gpio", 160'(got_src(0)), 160'(1));
        chk("R8 group over led", 160'(got_src(9)), 160'(4));
        wr(8'h1C, 32'h0);
        wr(8'h38, 32'h0000_0010);
        chk("R8 group over ctrl", 160'(got_src(35)), 160'(4));
        full_cmp("R8 mixed");
        wr(8'h10, 32'h0);
        wr(8'h38, 32'h0);
    endtask

    task automatic t_inputs();
        wr(8'h18, 32'hF0F0_F0F0);
        wr(8'h1C, 32'h0005_5555);
        wr(8'h38, 32'h0000_0014);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pad_in = {20'hC35A5 ^ 20'(k * 20'h1111), 32'h9E37_79B9 ^ (32'h0101_0101 * k)};
            gpio_out = ~gpio_out;
            alt_out = alt_out ^ 32'hFFFF_0000;
            #1; full_cmp("R10 input routing");
        end
    endtask

    initial begin
        gpio_out = 52'hA_BCDE_F012_3456; gpio_oe = 52'hF_0F0F_0F0F_0F0F;
        grp_out  = 52'h5_5555_AAAA_5555; grp_oe  = 52'hC_3C3C_3C3C_3C3C;
        led_out  = 24'h5A_C33C;
        alt_out  = 32'h0F0F_3C3C; alt_oe = 32'hFF00_F00F;
        sec_out  = 20'h9_6A5C;    sec_oe = 20'h3_C0FF;
        pad_in   = 52'h1_2345_6789_ABCD;
        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1;
        t_reset();
        t_regs();
        t_mode();
        t_led();
        t_ctrl();
        t_group();
        t_overlap();
        t_prio();
        t_inputs();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule